// File: doc/BRIEF.md
# Display pixel word unpacker

This block sits between a frame-buffer FIFO and a parallel panel bus. It takes 32-bit words over a valid/ready handshake and emits one pixel on each cycle where the dot-clock enable is high. Two source formats are handled. In the 16-bit format each word carries two RGB565 pixels. In the 32-bit format each word carries one pixel in its low three bytes.

The panel bus can be 8, 16, 18 or 24 lines wide, and any lines above the selected width are held at zero. On an 8-bit bus, 16-bit pixels go out one byte per enable. For an 18-bit panel fed from 32-bit words, a mapping flag keeps only the low six bits of each colour. Unsupported combinations of word length and bus width raise an error flag, and the block then stalls.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset, `pix_strobe` is 0, `pix_out` is 0, `cfg_err` is 0 for word length 0 with bus width 0, and `in_ready` is 1.
- R2: With word length code 0 (16-bit pixels) and a bus width other than 8 bits, each word yields two pixels. Bits 15:0 go out first and bits 31:16 go out second. Each pixel appears on `pix_out[15:0]` as red 15:11, green 10:5 and blue 4:0.
- R3: With word length code 0 and bus width code 1 (8 bits), each word yields four beats. They carry bytes 0, 1, 2 and 3 of the word, in that order, on `pix_out[7:0]`.
- R4: With word length code 3 (32-bit words) and the mapping flag clear, each word yields one pixel equal to word bits 23:0: red 23:16, green 15:8 and blue 7:0. Bits 31:24 have no effect on the output.
- R5: With word length code 3 and `cfg_map18` set, the pixel is {red[5:0], green[5:0], blue[5:0]} on `pix_out[17:0]`. The upper two bits of each component are dropped.
- R6: Bus width codes are 0 for 16 lines, 1 for 8, 2 for 18 and 3 for 24. Output lines at or above the selected width are 0 on every emitted pixel.
- R7: `cfg_err` is 1 for word length codes 1 and 2, and for code 3 combined with bus width code 1. While it is set, no word is accepted (`in_ready` is 0) and `pix_strobe` stays 0.
- R8: A new word is accepted only after every beat of the held word has been emitted. While a word is held, `in_ready` is 0 and words offered on the input are ignored.
- R9: A beat is emitted, with `pix_strobe` high for one cycle and `pix_out` updated, only on a cycle where `pix_en` is high and a word is held. Otherwise `pix_out` keeps its value.
- R10: When `pix_en` is high and no word is held (underrun), `pix_strobe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word_len | input | 2 | Source word length code (0 = 16-bit pixels, 3 = 32-bit pixel words) |
| cfg_bus_width | input | 2 | Panel bus width code (0 = 16, 1 = 8, 2 = 18, 3 = 24 lines) |
| cfg_map18 | input | 1 | Keep the low 6 bits of each 8-bit component |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | WORD_W | Frame-buffer word |
| pix_en | input | 1 | Dot-clock enable |
| pix_strobe | output | 1 | A beat was emitted this cycle |
| pix_out | output | PIX_W | Panel data bus |
| cfg_err | output | 1 | Unsupported configuration |

## Verification
The main function is tried with a table of words that covers each format and bus-width pairing. Asymmetric half-words show the order of the two 16-bit pixels. Four distinct bytes show the order of the 8-bit beats. A word with a non-zero top byte shows that this byte is ignored in the 32-bit format. Components with their upper two bits set show whether the 18-bit mapping trims the right bits. Running the same 18-bit mapping on a 16-line bus, and raw data on an 18-line bus, shows that masking by bus width is independent of the mapping. Directed cases cover the following:
- a stalled enable with a second word offered while one is held, which tells the hold rule apart from an early accept;
- underrun;
- each illegal code pairing.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 24;

  typedef enum logic [1:0] {
    WL_16B  = 2'd0,
    WL_RES1 = 2'd1,
    WL_RES2 = 2'd2,
    WL_32B  = 2'd3
  } wlen_e;

  typedef enum logic [1:0] {
    BW_16 = 2'd0,
    BW_8  = 2'd1,
    BW_18 = 2'd2,
    BW_24 = 2'd3
  } bwid_e;

  // number of output beats carried by one input word
  function automatic logic [2:0] beats_for(logic [1:0] wl, logic [1:0] bw);
    if (wl == WL_16B) return (bw == BW_8) ? 3'd4 : 3'd2;
    if (wl == WL_32B) return 3'd1;
    return 3'd0;
  endfunction

  function automatic logic cfg_bad(logic [1:0] wl, logic [1:0] bw);
    return (wl == WL_RES1) || (wl == WL_RES2) || (wl == WL_32B && bw == BW_8);
  endfunction

  // lines driven for a bus width code
  function automatic logic [PIX_W-1:0] lane_mask(logic [1:0] bw);
    logic [PIX_W-1:0] m;
    case (bw)
      BW_8:    m = {{(PIX_W-8){1'b0}},  {8{1'b1}}};
      BW_16:   m = {{(PIX_W-16){1'b0}}, {16{1'b1}}};
      BW_18:   m = {{(PIX_W-18){1'b0}}, {18{1'b1}}};
      default: m = {PIX_W{1'b1}};
    endcase
    return m;
  endfunction

  // keep the six low bits of each 8-bit colour component
  function automatic logic [PIX_W-1:0] trim666(logic [23:0] rgb);
    logic [PIX_W-1:0] r;
    r = '0;
    r[17:0] = {rgb[21:16], rgb[13:8], rgb[5:0]};
    return r;
  endfunction
endpackage

// File: rtl/pxu_cfg_check.sv
module pxu_cfg_check
  import pxu_pkg::*;
(
  input  logic [1:0] word_len,
  input  logic [1:0] bus_width,
  output logic       cfg_err,
  output logic [2:0] beats
);
  always_comb begin
    cfg_err = cfg_bad(word_len, bus_width);
    beats   = beats_for(word_len, bus_width);
  end
endmodule

// File: rtl/pxu_word_hold.sv
module pxu_word_hold #(
  parameter int WORD_W = 32,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              cfg_err,
  input  logic [2:0]        beats,
  input  logic              take,
  output logic [WORD_W-1:0] word_q,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              have_word,
  output logic              last_beat
);
  logic accept;

  assign in_ready  = !have_word && !cfg_err;
  assign accept    = in_valid && in_ready;
  assign last_beat = ({{(3-BEAT_W){1'b0}}, beat_idx} == (beats - 3'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q    <= '0;
      beat_idx  <= '0;
      have_word <= 1'b0;
    end else if (accept) begin
      word_q    <= in_data;
      beat_idx  <= '0;
      have_word <= 1'b1;
    end else if (take) begin
      if (last_beat) begin
        have_word <= 1'b0;
        beat_idx  <= '0;
      end else begin
        beat_idx  <= beat_idx + 1'b1;
      end
    end
  end

  assert_accept_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (have_word && beat_idx == '0));

  assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (have_word && !take) |=> (have_word && $stable(word_q) && $stable(beat_idx)));
endmodule

// File: rtl/pxu_pixel_fmt.sv
module pxu_pixel_fmt
  import pxu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24,
  parameter int BEAT_W = 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic [BEAT_W-1:0] beat_idx,
  input  logic [1:0]        word_len,
  input  logic [1:0]        bus_width,
  input  logic              map18,
  output logic [PIX_W-1:0]  pix
);
  localparam int NBYTES = WORD_W / 8;
  localparam int NHALF  = WORD_W / 16;

  logic [7:0]       byte_lane [NBYTES];
  logic [15:0]      half_lane [NHALF];
  logic [PIX_W-1:0] raw;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign byte_lane[g] = word[8*g +: 8];
  end
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign half_lane[h] = word[16*h +: 16];
  end

  always_comb begin
    raw = '0;
    case (word_len)
      WL_16B: begin
        if (bus_width == BW_8) raw[7:0]  = byte_lane[beat_idx];
        else                   raw[15:0] = half_lane[beat_idx[0]];
      end
      WL_32B: begin
        if (map18) raw = trim666(word[23:0]);
        else       raw = word[23:0];
      end
      default: raw = '0;
    endcase
    pix = raw & lane_mask(bus_width);
  end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pxu_pkg::*;
#(
  parameter int WORD_W = pxu_pkg::WORD_W,
  parameter int PIX_W  = pxu_pkg::PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_word_len,
  input  logic [1:0]        cfg_bus_width,
  input  logic              cfg_map18,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              pix_en,
  output logic              pix_strobe,
  output logic [PIX_W-1:0]  pix_out,
  output logic              cfg_err
);
  localparam int BEAT_W = $clog2(WORD_W / 8);

  logic [2:0]        beats;
  logic [WORD_W-1:0] word_q;
  logic [BEAT_W-1:0] beat_idx;
  logic              have_word;
  logic              last_beat;
  logic              take;
  logic [PIX_W-1:0]  pix_next;

  pxu_cfg_check u_cfg (
    .word_len (cfg_word_len),
    .bus_width(cfg_bus_width),
    .cfg_err  (cfg_err),
    .beats    (beats)
  );

  assign take = pix_en && have_word && !cfg_err;

  pxu_word_hold #(.WORD_W(WORD_W), .BEAT_W(BEAT_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .cfg_err  (cfg_err),
    .beats    (beats),
    .take     (take),
    .word_q   (word_q),
    .beat_idx (beat_idx),
    .have_word(have_word),
    .last_beat(last_beat)
  );

  pxu_pixel_fmt #(.WORD_W(WORD_W), .PIX_W(PIX_W), .BEAT_W(BEAT_W)) u_fmt (
    .word     (word_q),
    .beat_idx (beat_idx),
    .word_len (cfg_word_len),
    .bus_width(cfg_bus_width),
    .map18    (cfg_map18),
    .pix      (pix_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_strobe <= 1'b0;
      pix_out    <= '0;
    end else begin
      pix_strobe <= take;
      if (take) pix_out <= pix_next;
    end
  end

  assert_strobe_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |-> $past(pix_en));

  assert_out_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_strobe |-> $stable(pix_out));

  assert_no_strobe_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !pix_strobe);

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_strobe && $past(cfg_bus_width) == BW_16) |-> (pix_out[PIX_W-1:16] == '0));

  assert_trim_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_strobe && $past(cfg_map18) && $past(cfg_word_len) == WL_32B)
      |-> (pix_out[PIX_W-1:18] == '0));
endmodule

// File: tb/test_pixel_unpacker.sv
module test_pixel_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_word_len = 2'd0;
  logic [1:0]  cfg_bus_width = 2'd0;
  logic        cfg_map18 = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        pix_en = 1'b0;
  logic        pix_strobe;
  logic [23:0] pix_out;
  logic        cfg_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  pixel_unpacker i_pixel_unpacker (
    .clk(clk), .rst_n(rst_n),
    .cfg_word_len(cfg_word_len), .cfg_bus_width(cfg_bus_width), .cfg_map18(cfg_map18),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pix_en(pix_en), .pix_strobe(pix_strobe), .pix_out(pix_out), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [1:0]  wl;
    logic [1:0]  bw;
    logic        map;
    logic [31:0] data;
    logic [2:0]  nb;
    logic [95:0] exp;   // beat k at bits 24k+23:24k
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    // R2: low half first, on a 16-line bus
    '{2'd0, 2'd0, 1'b0, 32'hABCD_1234, 3'd2, {24'h0, 24'h0, 24'h00ABCD, 24'h001234}, 8'd2},
    // R2: RGB565 on a 24-line bus, upper lines zero
    '{2'd0, 2'd3, 1'b0, 32'hF800_07E0, 3'd2, {24'h0, 24'h0, 24'h00F800, 24'h0007E0}, 8'd2},
    // R3: 8-bit bus, bytes low first
    '{2'd0, 2'd1, 1'b0, 32'h8844_2211, 3'd4, {24'h000088, 24'h000044, 24'h000022, 24'h000011}, 8'd3},
    // R4: top byte ignored
    '{2'd3, 2'd3, 1'b0, 32'hFF12_3456, 3'd1, {72'h0, 24'h123456}, 8'd4},
    // R5: 24-to-18 mapping
    '{2'd3, 2'd2, 1'b1, 32'h00FF_C081, 3'd1, {72'h0, 24'h03F001}, 8'd5},
    // R6: mapping on a 16-line bus is masked to 16 lines
    '{2'd3, 2'd0, 1'b1, 32'h0012_3456, 3'd1, {72'h0, 24'h002D16}, 8'd6},
    // R6: raw 32-bit pixel on an 18-line bus
    '{2'd3, 2'd2, 1'b0, 32'h00AB_CDEF, 3'd1, {72'h0, 24'h03CDEF}, 8'd6}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    tick();
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 strobe", {31'b0, pix_strobe}, 32'd0);
    chk("R1 pix_out", {8'b0, pix_out}, 32'd0);
    chk("R1 ready", {31'b0, in_ready}, 32'd1);
    chk("R1 err", {31'b0, cfg_err}, 32'd0);
    rst_n = 1'b1;
    tick();

    // R10 underrun
    pix_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R10 no strobe on underrun", {31'b0, pix_strobe}, 32'd0);
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      cfg_word_len  = VECS[v].wl;
      cfg_bus_width = VECS[v].bw;
      cfg_map18     = VECS[v].map;
      pix_en        = 1'b1;
      chk($sformatf("R8 ready before vec %0d", v), {31'b0, in_ready}, 32'd1);
      push(VECS[v].data);
      for (int k = 0; k < int'(VECS[v].nb); k++) begin
        tick();
        chk($sformatf("R%0d vec %0d strobe beat %0d", VECS[v].req, v, k), {31'b0, pix_strobe}, 32'd1);
        chk($sformatf("R%0d vec %0d pixel beat %0d", VECS[v].req, v, k),
            {8'b0, pix_out}, {8'b0, VECS[v].exp[24*k +: 24]});
      end
      tick();
      chk($sformatf("R10 vec %0d no extra beat", v), {31'b0, pix_strobe}, 32'd0);
    end

    // R9 / R8: stalled enable, second word offered while busy
    cfg_word_len = 2'd0; cfg_bus_width = 2'd0; cfg_map18 = 1'b0;
    pix_en = 1'b0;
    held = pix_out;
    push(32'h5555_AAAA);
    in_valid = 1'b1;
    in_data  = 32'h1111_2222;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 no strobe while enable low", {31'b0, pix_strobe}, 32'd0);
      chk("R9 pix_out held", {8'b0, pix_out}, {8'b0, held});
      chk("R8 ready low while busy", {31'b0, in_ready}, 32'd0);
    end
    in_valid = 1'b0;
    pix_en = 1'b1;
    tick();
    chk("R8 first word beat 0", {8'b0, pix_out}, 32'h0000AAAA);
    tick();
    chk("R8 first word beat 1", {8'b0, pix_out}, 32'h00005555);
    tick();
    chk("R8 offered word was ignored", {31'b0, pix_strobe}, 32'd0);

    // R7 configuration errors
    cfg_word_len = 2'd1;
    #1;
    chk("R7 err code1", {31'b0, cfg_err}, 32'd1);
    chk("R7 ready low on err", {31'b0, in_ready}, 32'd0);
    in_valid = 1'b1; in_data = 32'h0BAD_0BAD;
    tick();
    chk("R7 no strobe on err", {31'b0, pix_strobe}, 32'd0);
    tick();
    chk("R7 no strobe on err 2", {31'b0, pix_strobe}, 32'd0);
    in_valid = 1'b0;
    cfg_word_len = 2'd2;
    #1;
    chk("R7 err code2", {31'b0, cfg_err}, 32'd1);
    cfg_word_len = 2'd3; cfg_bus_width = 2'd1;
    #1;
    chk("R7 err 32-bit on 8-bit bus", {31'b0, cfg_err}, 32'd1);
    cfg_bus_width = 2'd3;
    #1;
    chk("R7 no err 32-bit on 24-bit bus", {31'b0, cfg_err}, 32'd0);
    chk("R7 ready after err clears", {31'b0, in_ready}, 32'd1);
    tick();
    chk("R7 word offered during err not taken", {31'b0, pix_strobe}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule